// File: doc/BRIEF.md
# Data Address Generator and Region Decoder

This block forms the effective data-space address for the load and store operations of a small 8-bit controller core. It keeps three 16-bit pointers. Each pointer is assembled from two byte-wide working registers, and the core loads those registers one byte at a time. For every access the block applies one of five addressing modes, chosen by a mode code: absolute, pointer, pointer plus a small unsigned offset, pointer decremented before use, and pointer incremented after use. The two modes that change the pointer write the new value back on the clock edge of the access, and only when the access strobe is high.

The same effective address is decoded against a single linear map. That map holds the 32 working registers, then 64 I/O registers, then the internal SRAM, and everything above the SRAM is unmapped. The block drives exactly one region flag and gives an offset local to the selected region, which the storage arrays outside the block consume. A parameter sets the SRAM size to 256 or 512 bytes. The address, the region flags and the offset are combinational. Only the pointers are stored, and they clear on reset.

Top module: `data_addr_unit`

## Requirements
- R1: While rst_ni is low and after it is released, with no writes yet, all three pointers read as 0x0000.
- R2: With reg_we_i high, byte index 0..5 loads X low, X high, Y low, Y high, Z low, Z high on the next edge, and indexes 6 and 7 change nothing. ptr_sel_i is 0 for X, 1 for Y, and 2 or 3 for Z.
- R3: Mode 0 (absolute) drives addr_o from direct_addr_i and leaves every pointer unchanged.
- R4: Mode 1 (pointer) drives addr_o with the selected pointer and leaves it unchanged.
- R5: Mode 2 (offset) drives addr_o with pointer + zero-extended disp_i modulo 2^16 when Y or Z is selected. With X selected, disp_i is ignored and addr_o equals X.
- R6: Mode 3 (pre-decrement) drives addr_o with pointer − 1 modulo 2^16 and stores that value in the pointer on the edge where acc_valid_i is high.
- R7: Mode 4 (post-increment) drives addr_o with the pointer and stores pointer + 1 modulo 2^16 on the edge where acc_valid_i is high.
- R8: When acc_valid_i is low, no pointer changes except through byte writes.
- R9: When an update from modes 3 or 4 and a byte write target the same pointer in one cycle, the mode update is kept and the byte write is dropped.
- R10: Addresses 0x0000..0x001F raise sel_rf_o, with offset_o equal to the address.
- R11: Addresses 0x0020..0x005F raise sel_io_o, with offset_o equal to address − 0x20.
- R12: Addresses from 0x0060 to 0x0060 + SRAM_BYTES − 1 raise sel_sram_o, with offset_o equal to address − 0x60.
- R13: Any higher address raises unmapped_o only, with all selects low and offset_o zero. Exactly one of the four flags is high at any time.
- R14: Mode codes 5, 6 and 7 behave as mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe; enables pointer update |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer select |
| disp_i | input | 6 | Unsigned offset for mode 2 |
| direct_addr_i | input | 16 | Absolute address for mode 0 |
| reg_we_i | input | 1 | Pointer byte write enable |
| reg_idx_i | input | 3 | Pointer byte index |
| reg_wdata_i | input | 8 | Pointer byte data |
| addr_o | output | 16 | Effective address |
| sel_rf_o | output | 1 | Working register region |
| sel_io_o | output | 1 | I/O region |
| sel_sram_o | output | 1 | SRAM region |
| unmapped_o | output | 1 | Address outside all regions |
| offset_o | output | $clog2(SRAM_BYTES) | Offset within the selected region |

## Verification
The assertions check four things on every cycle. The region flags must be one-hot, and an unmapped address must give a zero offset. The working register and I/O offsets must stay in range. Each pointer update must match the address the access used, and pointers must hold when no update or write is requested. The bench scenarios cover the rest: the exact addresses at each region boundary for the configured SRAM size, wrap-around at 0x0000 and 0xFFFF, the ignored offset on X, the unused byte indexes and mode codes, and the priority of a mode update over a byte write to the same pointer.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int PTR_W  = 16;
  localparam int N_PTR  = 3;
  localparam int DISP_W = 6;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_IND     = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_PREDEC  = 3'd3,
    MODE_POSTINC = 3'd4
  } dag_mode_e;

  localparam logic [PTR_W-1:0] IO_BASE   = 16'h0020;
  localparam logic [PTR_W-1:0] SRAM_BASE = 16'h0060;
endpackage

// File: rtl/dag_ptr_regs.sv
module dag_ptr_regs
  import dag_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wb_en_i,
  input  logic [1:0]                  wb_sel_i,
  input  logic [PTR_W-1:0]            wb_val_i,
  input  logic                        byte_we_i,
  input  logic [2:0]                  byte_idx_i,
  input  logic [7:0]                  byte_data_i,
  output logic [N_PTR-1:0][PTR_W-1:0] ptr_o
);
  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic hit_wb, hit_byte;
    assign hit_wb   = wb_en_i && (wb_sel_i == 2'(g));
    assign hit_byte = byte_we_i && (byte_idx_i[2:1] == 2'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_o[g] <= '0;
      end else if (hit_wb) begin
        ptr_o[g] <= wb_val_i;            // mode update beats byte write
      end else if (hit_byte) begin
        if (byte_idx_i[0]) ptr_o[g][15:8] <= byte_data_i;
        else               ptr_o[g][7:0]  <= byte_data_i;
      end
    end
  end
endmodule

// File: rtl/dag_agu.sv
module dag_agu
  import dag_pkg::*;
(
  input  logic [2:0]                  mode_i,
  input  logic [1:0]                  sel_i,
  input  logic [N_PTR-1:0][PTR_W-1:0] ptr_i,
  input  logic [DISP_W-1:0]           disp_i,
  input  logic [PTR_W-1:0]            direct_i,
  output logic [PTR_W-1:0]            addr_o,
  output logic                        upd_o,
  output logic [PTR_W-1:0]            upd_val_o
);
  logic [PTR_W-1:0] base, dec, inc;

  assign base = ptr_i[sel_i];
  assign dec  = base - 16'd1;
  assign inc  = base + 16'd1;

  always_comb begin
    addr_o    = base;
    upd_o     = 1'b0;
    upd_val_o = base;
    case (mode_i)
      MODE_DIRECT: addr_o = direct_i;
      MODE_DISP:   addr_o = (sel_i == 2'd0) ? base : base + PTR_W'(disp_i);
      MODE_PREDEC: begin
        addr_o    = dec;
        upd_o     = 1'b1;
        upd_val_o = dec;
      end
      MODE_POSTINC: begin
        upd_o     = 1'b1;
        upd_val_o = inc;
      end
      default: addr_o = base;
    endcase
  end
endmodule

// File: rtl/dag_decode.sv
module dag_decode
  import dag_pkg::*;
#(
  parameter int SRAM_BYTES = 512,
  localparam int OFF_W = $clog2(SRAM_BYTES)
) (
  input  logic [PTR_W-1:0] addr_i,
  output logic             rf_o,
  output logic             io_o,
  output logic             sram_o,
  output logic             unm_o,
  output logic [OFF_W-1:0] off_o
);
  localparam logic [PTR_W-1:0] SRAM_TOP = PTR_W'(int'(SRAM_BASE) + SRAM_BYTES - 1);

  logic [PTR_W-1:0] io_rel, sram_rel;
  assign io_rel   = addr_i - IO_BASE;
  assign sram_rel = addr_i - SRAM_BASE;

  always_comb begin
    rf_o   = 1'b0;
    io_o   = 1'b0;
    sram_o = 1'b0;
    unm_o  = 1'b0;
    off_o  = '0;
    if (addr_i < IO_BASE) begin
      rf_o  = 1'b1;
      off_o = OFF_W'(addr_i[4:0]);
    end else if (addr_i < SRAM_BASE) begin
      io_o  = 1'b1;
      off_o = OFF_W'(io_rel[5:0]);
    end else if (addr_i <= SRAM_TOP) begin
      sram_o = 1'b1;
      off_o  = sram_rel[OFF_W-1:0];
    end else begin
      unm_o = 1'b1;
    end
  end
endmodule

// File: rtl/data_addr_unit.sv
module data_addr_unit
  import dag_pkg::*;
#(
  parameter int SRAM_BYTES = 512,       // 256 or 512
  localparam int OFF_W = $clog2(SRAM_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [2:0]         mode_i,
  input  logic [1:0]         ptr_sel_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [PTR_W-1:0]   direct_addr_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_idx_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [PTR_W-1:0]   addr_o,
  output logic               sel_rf_o,
  output logic               sel_io_o,
  output logic               sel_sram_o,
  output logic               unmapped_o,
  output logic [OFF_W-1:0]   offset_o
);
  logic [1:0]                  sel_n;
  logic [N_PTR-1:0][PTR_W-1:0] ptr_q;
  logic                        upd;
  logic [PTR_W-1:0]            upd_val;

  assign sel_n = (ptr_sel_i == 2'd3) ? 2'd2 : ptr_sel_i;

  dag_ptr_regs u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wb_en_i     (acc_valid_i && upd),
    .wb_sel_i    (sel_n),
    .wb_val_i    (upd_val),
    .byte_we_i   (reg_we_i),
    .byte_idx_i  (reg_idx_i),
    .byte_data_i (reg_wdata_i),
    .ptr_o       (ptr_q)
  );

  dag_agu u_agu (
    .mode_i    (mode_i),
    .sel_i     (sel_n),
    .ptr_i     (ptr_q),
    .disp_i    (disp_i),
    .direct_i  (direct_addr_i),
    .addr_o    (addr_o),
    .upd_o     (upd),
    .upd_val_o (upd_val)
  );

  dag_decode #(.SRAM_BYTES(SRAM_BYTES)) u_dec (
    .addr_i (addr_o),
    .rf_o   (sel_rf_o),
    .io_o   (sel_io_o),
    .sram_o (sel_sram_o),
    .unm_o  (unmapped_o),
    .off_o  (offset_o)
  );

  AST_PREDEC_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && mode_i == MODE_PREDEC) |=> ptr_q[$past(sel_n)] == $past(addr_o)); // R6
  AST_POSTINC_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && mode_i == MODE_POSTINC) |=>
      ptr_q[$past(sel_n)] == PTR_W'($past(addr_o) + 16'd1)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !(acc_valid_i && (mode_i == MODE_PREDEC || mode_i == MODE_POSTINC)))
      |=> $stable(ptr_q)); // R8
  AST_ONE_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({sel_rf_o, sel_io_o, sel_sram_o, unmapped_o})); // R13
  AST_UNMAPPED_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> offset_o == '0); // R13
  AST_RF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rf_o |-> (addr_o < 16'h20 && offset_o < OFF_W'(32))); // R10
  AST_IO_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_io_o |-> offset_o < OFF_W'(64)); // R11
endmodule

// File: tb/data_addr_unit_tb.sv
module data_addr_unit_tb_top;
  localparam int SRAM_BYTES = 512;
  localparam int OFF_W = $clog2(SRAM_BYTES);
  localparam int SRAM_TOP = 16'h60 + SRAM_BYTES - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_ni;
  logic             acc_valid;
  logic [2:0]       mode;
  logic [1:0]       psel;
  logic [5:0]       disp;
  logic [15:0]      daddr;
  logic             we;
  logic [2:0]       idx;
  logic [7:0]       wdata;
  logic [15:0]      addr;
  logic             s_rf, s_io, s_sram, s_unm;
  logic [OFF_W-1:0] ofs;

  data_addr_unit #(.SRAM_BYTES(SRAM_BYTES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid), .mode_i(mode),
    .ptr_sel_i(psel), .disp_i(disp), .direct_addr_i(daddr), .reg_we_i(we),
    .reg_idx_i(idx), .reg_wdata_i(wdata), .addr_o(addr), .sel_rf_o(s_rf),
    .sel_io_o(s_io), .sel_sram_o(s_sram), .unmapped_o(s_unm), .offset_o(ofs)
  );

  int checks = 0;
  int errors = 0;
  int mp[3];
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, int m, int s, int d, int da, bit w, int i, int wd);
    acc_valid = v; mode = 3'(m); psel = 2'(s); disp = 6'(d);
    daddr = 16'(da); we = w; idx = 3'(i); wdata = 8'(wd);
  endtask

  // compare outputs mid-cycle, then advance the reference state
  task automatic step(string tag);
    int s, b, ea, nb, eo, ef, pi;
    bit upd;
    string rtag;
    #2;
    s = (psel == 2'd3) ? 2 : int'(psel);
    b = mp[s]; nb = b; upd = 0;
    case (mode)
      3'd0: ea = int'(daddr);
      3'd2: ea = (s == 0) ? b : ((b + int'(disp)) & 16'hFFFF);
      3'd3: begin ea = (b - 1) & 16'hFFFF; nb = ea; upd = 1; end
      3'd4: begin ea = b; nb = (b + 1) & 16'hFFFF; upd = 1; end
      default: ea = b;
    endcase
    chk(int'(addr) == ea, tag, int'(addr), ea);
    if (ea < 16'h20)          begin ef = 8; eo = ea;         rtag = "R10"; end
    else if (ea < 16'h60)     begin ef = 4; eo = ea - 16'h20; rtag = "R11"; end
    else if (ea <= SRAM_TOP)  begin ef = 2; eo = ea - 16'h60; rtag = "R12"; end
    else                      begin ef = 1; eo = 0;           rtag = "R13"; end
    chk(int'({s_rf, s_io, s_sram, s_unm}) == ef && int'(ofs) == eo, rtag,
        int'({s_rf, s_io, s_sram, s_unm, ofs}), (ef << OFF_W) | eo);
    if (rst_ni) begin
      if (we && idx < 3'd6) begin
        pi = int'(idx) / 2;
        if (!(acc_valid && upd && pi == s)) begin
          if (idx[0]) mp[pi] = (mp[pi] & 16'h00FF) | (int'(wdata) << 8);
          else        mp[pi] = (mp[pi] & 16'hFF00) | int'(wdata);
        end
      end
      if (acc_valid && upd) mp[s] = nb;
    end
    @(negedge clk);
  endtask

  task automatic load_ptr(int s, int v);
    drive(0, 1, 0, 0, 0, 1, 2 * s, v & 8'hFF);     step("R2");
    drive(0, 1, 0, 0, 0, 1, 2 * s + 1, v >> 8);    step("R2");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    string mtag[8] = '{"R3", "R4", "R5", "R6", "R7", "R14", "R14", "R14"};
    mp[0] = 0; mp[1] = 0; mp[2] = 0;
    rst_ni = 1'b0;
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin drive(0, 1, s, 0, 0, 1, 2 * s, 8'h55); step("R1"); end
    rst_ni = 1'b1;
    for (int s = 0; s < 3; s++) begin drive(1, 1, s, 0, 0, 0, 0, 0); step("R1"); end

    load_ptr(0, 16'h1234); load_ptr(1, 16'h0100); load_ptr(2, 16'h025F);
    drive(0, 1, 0, 0, 0, 1, 6, 8'hAA); step("R2");
    drive(0, 1, 0, 0, 0, 1, 7, 8'hBB); step("R2");
    for (int s = 0; s < 3; s++) begin drive(1, 1, s, 0, 0, 0, 0, 0); step("R4"); end
    drive(1, 1, 3, 0, 0, 0, 0, 0); step("R2");

    drive(1, 0, 1, 0, 16'h005F, 0, 0, 0); step("R3");
    drive(1, 0, 2, 0, 16'h0260, 0, 0, 0); step("R3");
    drive(1, 1, 2, 0, 0, 0, 0, 0); step("R3");

    drive(1, 2, 1, 63, 0, 0, 0, 0); step("R5");
    drive(1, 2, 3, 1, 0, 0, 0, 0); step("R5");
    drive(1, 2, 0, 10, 0, 0, 0, 0); step("R5");

    load_ptr(0, 16'h0000);
    drive(1, 3, 0, 0, 0, 0, 0, 0); step("R6");
    drive(1, 1, 0, 0, 0, 0, 0, 0); step("R6");
    drive(1, 4, 0, 0, 0, 0, 0, 0); step("R7");
    drive(1, 1, 0, 0, 0, 0, 0, 0); step("R7");
    drive(0, 4, 1, 0, 0, 0, 0, 0); step("R8");
    drive(0, 3, 1, 0, 0, 0, 0, 0); step("R8");
    drive(1, 1, 1, 0, 0, 0, 0, 0); step("R8");

    drive(1, 4, 2, 0, 0, 1, 4, 8'h00); step("R9");
    drive(1, 1, 2, 0, 0, 0, 0, 0); step("R9");
    drive(1, 3, 1, 0, 0, 1, 0, 8'h77); step("R9");
    drive(1, 1, 0, 0, 0, 0, 0, 0); step("R9");
    drive(1, 1, 1, 0, 0, 0, 0, 0); step("R9");

    for (int m = 5; m < 8; m++) begin drive(1, m, 1, 9, 16'h0003, 0, 0, 0); step("R14"); end

    foreach (mtag[k]) begin end
    begin
      int edges[8] = '{16'h001F, 16'h0020, 16'h005F, 16'h0060,
                       SRAM_TOP, SRAM_TOP + 1, 16'hFFFF, 16'h0000};
      foreach (edges[k]) begin drive(1, 0, 0, 0, edges[k], 0, 0, 0); step("R3"); end
    end

    for (int n = 0; n < 400; n++) begin
      int m;
      m = $urandom_range(0, 7);
      drive($urandom_range(0, 1), m, $urandom_range(0, 3), $urandom_range(0, 63),
            $urandom_range(0, 16'h0300), $urandom_range(0, 1),
            $urandom_range(0, 7), $urandom_range(0, 255));
      step(mtag[m]);
    end
    finish_run();
  end
endmodule